// File: doc/BRIEF.md
# Single-Wire Bus Slot Timing Master

This block produces the master-side waveforms of an open-drain single-wire bus at the level of a single slot. A requester hands it one command at a time: write a one, write a zero, read one bit, or a bus reset with a check for presence. The block pulls the selected bus lanes low and releases them, each phase lasting a fixed number of microseconds. It samples the synchronized bus level at a fixed point in the slot. When the slot ends it returns the read bit or a per-lane presence mask.

Each microsecond is a tick of `CLK_PER_US` system clocks, and every phase lasts a whole number of ticks. The tick divider restarts when a command is accepted, so all phase boundaries fall on exact clock counts measured from acceptance. Writes and resets can act on several lanes at the same time. A read must name exactly one lane. There is no upper limit on the time between commands.

Top module: `owire_slot_master`

## Requirements
- R1: While `rst_ni` is low, `bus_pull_o` is all zero and `done_o` is low. After reset is released, `cmd_ready_o` stays low for 410 µs (410·`CLK_PER_US` cycles) and then rises. No `done_o` pulse is given for this start-up wait.
- R2: A command is accepted at a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high and the command is legal. `cmd_ready_o` then stays low until the slot ends. The end of the slot is marked by a one-cycle `done_o` pulse, and `cmd_ready_o` is high in that same cycle.
- R3: `cmd_i` is one-hot. Bit 0 selects write-1, bit 1 write-0, bit 2 read and bit 3 reset. A request is ignored if `cmd_i` is not one-hot, if `lane_mask_i` is zero, or if it is a read whose mask has more than one bit set. An ignored request causes no pull, no `done_o` pulse, and `cmd_ready_o` stays high.
- R4: Write-1 pulls the addressed lanes low for 6 µs. The whole slot lasts 70 µs from acceptance to completion.
- R5: Write-0 pulls the addressed lanes low for 60 µs. The whole slot lasts 70 µs.
- R6: Read pulls the one addressed lane low for 6 µs and samples it 15 µs after the falling edge. The slot lasts 70 µs. `rd_bit_o` is 1 for a high sample and 0 for a low sample, and it holds that value until the next read completes.
- R7: Reset pulls the addressed lanes low for 480 µs and samples them 70 µs after release. The slot lasts 960 µs. A `presence_o` bit is 1 only when its lane was addressed and sampled low. `presence_o` holds until the next reset completes.
- R8: During any slot, `bus_pull_o` is high only on lanes set in the accepted mask, and all of those lanes switch together.
- R9: Every phase lasts an exact multiple of `CLK_PER_US` clocks, counted from the accepting edge. `bus_pull_o` changes only on a tick or on acceptance. `bus_i` passes through a two-flop synchronizer before it is sampled.
- R10: The block can stay idle for any length of time between commands and still accept the next one with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Block idle and able to take a command |
| cmd_i | input | 4 | One-hot command: write-1, write-0, read, reset |
| lane_mask_i | input | NUM_LANES | Lanes addressed by the command |
| done_o | output | 1 | One-cycle pulse at slot end |
| rd_bit_o | output | 1 | Bit returned by the last read |
| presence_o | output | NUM_LANES | Per-lane presence from the last reset |
| bus_pull_o | output | NUM_LANES | Active-high pull-low drive per lane |
| bus_i | input | NUM_LANES | Raw bus level per lane |

## Verification
The bench models a slave on each lane. On a read, a slave holding a zero keeps the line low for only 20 µs after the falling edge. A design that samples late would therefore read 1 where 0 is expected. A presence pulse is emitted only from 30 µs to 130 µs after a long low period, so a reset sampled at the wrong point reports the wrong mask. Pull widths and busy periods are measured in clocks, which catches a tick divider that is off by one or a phase that is skipped. Illegal encodings, empty masks, multi-lane reads, unaddressed lanes that must read as absent, and a long idle gap are each checked at the ports.

// File: rtl/owm_pkg.sv
package owm_pkg;
  localparam int CMD_W   = 4;
  localparam int CMD_WR1 = 0;
  localparam int CMD_WR0 = 1;
  localparam int CMD_RD  = 2;
  localparam int CMD_RST = 3;
  localparam int US_W    = 10;

  localparam logic [US_W-1:0] T_RECOVERY = US_W'(410);

  typedef enum logic [2:0] {
    ST_RECOV, ST_IDLE, ST_LOW, ST_WAIT1, ST_WAIT2
  } owm_state_e;

  typedef struct packed {
    logic [US_W-1:0] low_us;   // pull duration
    logic [US_W-1:0] smp_us;   // release to sample
    logic [US_W-1:0] tail_us;  // sample to done
  } slot_time_t;

  function automatic slot_time_t slot_time(input logic [CMD_W-1:0] cmd);
    slot_time_t t;
    t = '{low_us: US_W'(6), smp_us: US_W'(64), tail_us: US_W'(0)};
    if (cmd[CMD_WR0]) t = '{low_us: US_W'(60),  smp_us: US_W'(10), tail_us: US_W'(0)};
    if (cmd[CMD_RD])  t = '{low_us: US_W'(6),   smp_us: US_W'(9),  tail_us: US_W'(55)};
    if (cmd[CMD_RST]) t = '{low_us: US_W'(480), smp_us: US_W'(70), tail_us: US_W'(410)};
    return t;
  endfunction
endpackage

// File: rtl/owm_tick_gen.sv
module owm_tick_gen #(
  parameter int CLK_PER_US = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LIM = CW'(CLK_PER_US - 1);

  logic [CW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pre_q <= '0;
    else if (restart_i || tick_o)  pre_q <= '0;
    else                           pre_q <= pre_q + 1'b1;
  end

  assign tick_o = (pre_q == LIM);

  generate
    if (CLK_PER_US > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o) else $error("tick too dense"); // R9
    end
  endgenerate
endmodule

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int NUM_LANES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LANES-1:0] bus_i,
  output logic [NUM_LANES-1:0] bus_s_o
);
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic ff1_q, ff2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff1_q <= 1'b1;
        ff2_q <= 1'b1;
      end else begin
        ff1_q <= bus_i[l];
        ff2_q <= ff1_q;
      end
    end
    assign bus_s_o[l] = ff2_q;
  end
endmodule

// File: rtl/owm_slot_fsm.sv
module owm_slot_fsm
  import owm_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 accept_i,
  input  logic [CMD_W-1:0]     cmd_i,
  input  logic [NUM_LANES-1:0] mask_i,
  input  logic [NUM_LANES-1:0] bus_s_i,
  output logic                 ready_o,
  output logic                 done_o,
  output logic                 rd_bit_o,
  output logic [NUM_LANES-1:0] presence_o,
  output logic [NUM_LANES-1:0] pull_o
);
  owm_state_e          state_q;
  logic [US_W-1:0]     us_q;
  logic [CMD_W-1:0]    cmd_q;
  logic [NUM_LANES-1:0] mask_q;
  slot_time_t          tim_cur, tim_new;
  logic                last_us;

  assign tim_cur = slot_time(cmd_q);
  assign tim_new = slot_time(cmd_i);
  assign last_us = tick_i && (us_q == US_W'(1));
  assign ready_o = (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RECOV;
      us_q       <= T_RECOVERY;
      cmd_q      <= '0;
      mask_q     <= '0;
      pull_o     <= '0;
      done_o     <= 1'b0;
      rd_bit_o   <= 1'b0;
      presence_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (tick_i && !last_us && state_q != ST_IDLE) us_q <= us_q - 1'b1;
      unique case (state_q)
        ST_RECOV: if (last_us) state_q <= ST_IDLE;
        ST_IDLE: if (accept_i) begin
          state_q <= ST_LOW;
          cmd_q   <= cmd_i;
          mask_q  <= mask_i;
          pull_o  <= mask_i;
          us_q    <= tim_new.low_us;
        end
        ST_LOW: if (last_us) begin
          pull_o  <= '0;
          state_q <= ST_WAIT1;
          us_q    <= tim_cur.smp_us;
        end
        ST_WAIT1: if (last_us) begin
          if (cmd_q[CMD_RD])  rd_bit_o   <= |(bus_s_i & mask_q);
          if (cmd_q[CMD_RST]) presence_o <= ~bus_s_i & mask_q;
          if (tim_cur.tail_us == '0) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end else begin
            state_q <= ST_WAIT2;
            us_q    <= tim_cur.tail_us;
          end
        end
        ST_WAIT2: if (last_us) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R2
  AST_DONE_WHEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o) else $error("done while busy"); // R2
  AST_PULL_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|pull_o) |-> $past(accept_i)) else $error("pull without command"); // R8
  AST_PULL_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pull_o) |-> $past(tick_i || accept_i)) else $error("pull moved off tick"); // R9
endmodule

// File: rtl/owire_slot_master.sv
module owire_slot_master
  import owm_pkg::*;
#(
  parameter int CLK_PER_US = 125,
  parameter int NUM_LANES  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  output logic                 cmd_ready_o,
  input  logic [CMD_W-1:0]     cmd_i,
  input  logic [NUM_LANES-1:0] lane_mask_i,
  output logic                 done_o,
  output logic                 rd_bit_o,
  output logic [NUM_LANES-1:0] presence_o,
  output logic [NUM_LANES-1:0] bus_pull_o,
  input  logic [NUM_LANES-1:0] bus_i
);
  logic                 tick, accept, legal;
  logic [NUM_LANES-1:0] bus_s;

  // read may name only one lane; writes and reset take any non-empty mask
  assign legal  = $onehot(cmd_i) && (lane_mask_i != '0) &&
                  (!cmd_i[CMD_RD] || $onehot(lane_mask_i));
  assign accept = cmd_valid_i && cmd_ready_o && legal;

  owm_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk_i, .rst_ni, .restart_i(accept), .tick_o(tick)
  );

  owm_sync #(.NUM_LANES(NUM_LANES)) u_sync (
    .clk_i, .rst_ni, .bus_i, .bus_s_o(bus_s)
  );

  owm_slot_fsm #(.NUM_LANES(NUM_LANES)) u_fsm (
    .clk_i, .rst_ni,
    .tick_i(tick), .accept_i(accept), .cmd_i, .mask_i(lane_mask_i),
    .bus_s_i(bus_s), .ready_o(cmd_ready_o), .done_o, .rd_bit_o,
    .presence_o, .pull_o(bus_pull_o)
  );

  AST_IGNORE_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && !legal) |=> (cmd_ready_o && bus_pull_o == '0))
    else $error("illegal request acted on"); // R3
endmodule

// File: tb/owire_slot_master_bench.sv
`timescale 1ns/1ps
module owire_slot_master_bench;
  localparam int K = 4;
  localparam int L = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [3:0]   cmd = '0;
  logic [L-1:0] mask = '0;
  logic         ready, done, rd_bit;
  logic [L-1:0] pres, pull, bus, slave_low;

  logic [L-1:0] rd_zero = '0;
  logic [L-1:0] present = '0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  owire_slot_master #(.CLK_PER_US(K), .NUM_LANES(L)) u_owire_slot_master (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_ready_o(ready),
    .cmd_i(cmd), .lane_mask_i(mask), .done_o(done), .rd_bit_o(rd_bit),
    .presence_o(pres), .bus_pull_o(pull), .bus_i(bus)
  );

  assign bus = ~(pull | slave_low);

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // slave model: read-zero holds 20 us from fall; presence 30..130 us after a long low
  int fall_c[L], low_len[L], rel_c[L];
  logic [L-1:0] pull_prev = '0;
  initial for (int l = 0; l < L; l++) begin
    fall_c[l] = 100000; low_len[l] = 0; rel_c[l] = 100000;
  end
  initial slave_low = '0;
  always @(negedge clk) begin
    for (int l = 0; l < L; l++) begin
      if (pull[l] && !pull_prev[l]) begin fall_c[l] = 0; low_len[l] = 0; end
      else fall_c[l]++;
      if (pull[l]) low_len[l]++;
      if (!pull[l] && pull_prev[l]) rel_c[l] = 0; else rel_c[l]++;
      slave_low[l] = (rd_zero[l] && fall_c[l] < 20*K) ||
                     (present[l] && low_len[l] >= 400*K && rel_c[l] >= 30*K && rel_c[l] < 130*K);
    end
    pull_prev = pull;
  end

  typedef struct {
    string      req;
    int         low_cyc;
    int         busy_cyc;
    logic [L-1:0] pull_mask;
    bit         is_rd;
    bit         is_rst;
    logic       exp_bit;
    logic [L-1:0] exp_pres;
  } exp_t;
  exp_t sb[$];

  bit mon_en = 0;
  int busy_n = 0, low_n = 0, done_multi = 0;
  logic [L-1:0] seen_pull = '0;
  logic done_prev = 1'b0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (done && done_prev) done_multi++;
      if (!ready) busy_n++;
      if (|pull) low_n++;
      seen_pull |= pull;
      if (done) begin
        if (sb.size() == 0) chk(0, "R2 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(low_n == e.low_cyc, {e.req, " R9 pull width"}, low_n, e.low_cyc);
          chk(busy_n == e.busy_cyc, {e.req, " R2 slot length"}, busy_n, e.busy_cyc);
          chk(seen_pull == e.pull_mask, {e.req, " R8 pulled lanes"}, seen_pull, e.pull_mask);
          if (e.is_rd) chk(rd_bit == e.exp_bit, {e.req, " read bit"}, rd_bit, e.exp_bit);
          if (e.is_rst) chk(pres == e.exp_pres, {e.req, " presence"}, pres, e.exp_pres);
        end
        busy_n = 0; low_n = 0; seen_pull = '0;
      end
    end
    done_prev = done;
  end

  task automatic issue(input string req, input logic [3:0] c, input logic [L-1:0] m,
                       input int low_us, input int tot_us, input logic eb, input logic [L-1:0] ep);
    exp_t e;
    while (!ready) @(negedge clk);
    e.req = req; e.low_cyc = low_us*K; e.busy_cyc = tot_us*K; e.pull_mask = m;
    e.is_rd = c[2]; e.is_rst = c[3]; e.exp_bit = eb; e.exp_pres = ep;
    sb.push_back(e);
    valid = 1'b1; cmd = c; mask = m;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic try_illegal(input string req, input logic [3:0] c, input logic [L-1:0] m);
    int viol = 0;
    while (!ready) @(negedge clk);
    valid = 1'b1; cmd = c; mask = m;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!ready || pull != '0 || done) viol++;
    end
    valid = 1'b0;
    chk(viol == 0, {req, " R3 illegal ignored"}, viol, 0);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(pull == '0 && !done, "R1 reset outputs", {pull, done}, 0);
    rst_n = 1'b1;
    n = 0;
    while (!ready && n < 5000) begin n++; @(negedge clk); end
    chk(n == 410*K, "R1 power-up wait", n, 410*K);
    chk(sb.size() == 0 && !done, "R1 no done at start-up", done, 0);
    mon_en = 1;

    issue("R4 write-1", 4'b0001, 4'b0001, 6, 70, 1'b0, '0);
    issue("R5 write-0", 4'b0010, 4'b1010, 60, 70, 1'b0, '0);
    rd_zero = 4'b0010;
    issue("R6 read lane1 zero", 4'b0100, 4'b0010, 6, 70, 1'b0, '0);
    issue("R6 read lane2 one", 4'b0100, 4'b0100, 6, 70, 1'b1, '0);
    while (!ready || sb.size() != 0) @(negedge clk);
    rd_zero = '0;
    present = 4'b0101;
    issue("R7 reset multi", 4'b1000, 4'b0111, 480, 960, 1'b0, 4'b0101);
    issue("R7 reset absent", 4'b1000, 4'b1000, 480, 960, 1'b0, 4'b0000);
    issue("R7 reset all", 4'b1000, 4'b1111, 480, 960, 1'b0, 4'b0101);
    issue("R8 write-1 wide", 4'b0001, 4'b1111, 6, 70, 1'b0, '0);
    while (!ready || sb.size() != 0) @(negedge clk);
    chk(pres == 4'b0101, "R7 presence held", pres, 4'b0101);

    try_illegal("two-hot", 4'b0011, 4'b0001);
    try_illegal("empty mask", 4'b0001, 4'b0000);
    try_illegal("read two lanes", 4'b0100, 4'b0011);
    try_illegal("no command", 4'b0000, 4'b0001);

    repeat (5000) @(negedge clk);
    rd_zero = 4'b1000;
    issue("R10 read after idle", 4'b0100, 4'b1000, 6, 70, 1'b0, '0);
    while (!ready || sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done_multi == 0, "R2 done single cycle", done_multi, 0);
    chk(sb.size() == 0, "R2 all slots completed", sb.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule